// File: doc/BRIEF.md
# Audio Serial Bit-Clock Generator

This block turns one fast audio source clock into the three timing signals of a stereo serial audio link: an oversampled master clock, the serial bit clock and the left/right word-select strobe. A programmable linear divider splits the source clock by an even or odd ratio. Its output is reshaped so that the high and low phases differ by at most one source cycle.

When the master-clock path is selected, the divided clock leaves as the master clock. A fixed post-divider then derives the bit clock from it, with a ratio of 8 for 16-bit channel slots and 4 for 32-bit channel slots. In both cases the master clock runs at 256 times the sample rate. When the master-clock path is off, the divided clock is used directly as the bit clock and the master-clock pin stays low. Word select marks the channel slots on the bit-clock falling edge.

All outputs are registers or muxes of registers in the source clock domain. Settings are captured only while the block is idle, so they are always consistent during a run.

Top module: `audio_clkgen`

## Requirements
- R1: While enabled, the divided clock repeats every 2*N+O source cycles, where N is `div_n` and O is `odd_sel`. After the first source edge that samples `en` high, the divided clock is high.
- R2: Each period of the divided clock is high for N+O source cycles and low for N source cycles.
- R3: A `div_n` value of 0 or 1 gives exactly the waveform of `div_n` = 2 with the same `odd_sel`.
- R4: With `mclk_en` = 1, `mclk_o` carries the divided clock. `bclk_o` is `mclk_o` divided by 8 when `frame32` = 0, and by 4 when `frame32` = 1. `bclk_o` changes only together with a rising edge of `mclk_o`, and it is high in the first half of each of its periods.
- R5: With `mclk_en` = 0, `bclk_o` carries the divided clock and `mclk_o` stays low.
- R6: `ws_o` starts low after enable. It changes only on the same source edge on which `bclk_o` falls, and it toggles after every 16 (`frame32` = 0) or 32 (`frame32` = 1) bit-clock falling edges.
- R7: `div_n`, `odd_sel`, `mclk_en` and `frame32` are captured on every source edge at which `en` is low. Changing them while `en` is high has no effect on any output.
- R8: After a source edge that samples `rst_n` low or `en` low, `mclk_o`, `bclk_o` and `ws_o` are all low. A later enable restarts every counter from zero and reproduces the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast audio source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; settings are captured while low |
| div_n | input | 8 | Linear divide value N |
| odd_sel | input | 1 | Adds one to the divide ratio |
| mclk_en | input | 1 | 1: master-clock path with post-divider; 0: direct bit clock |
| frame32 | input | 1 | Channel slot width: 0 = 16 bits, 1 = 32 bits |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |

## Verification
Each output is a register, or a mux of registers fed from the captured settings, so the effect of a sampled `en` or `rst_n` appears one source edge later. If `en` is first seen high at edge 0, then after edge k the divided clock equals ((k mod (2N+O)) < N+O). The bit clock on the master-clock path flips at every half-ratio count of master-clock rising edges, counted from edge 0, and word select follows a count of the bit clock's falling edges. The bench evaluates these closed forms for each edge index and compares them with the outputs on the following falling clock edge. A disable or reset is checked on the falling edge right after the first rising edge that samples it.

// File: rtl/acg_pkg.sv
// Package: shared sizing constants and the captured-settings record for
// the audio serial clock generator. Assumes a single source clock domain.
package acg_pkg;
    localparam int DIV_W       = 8;   // width of the linear divide value
    localparam int MIN_DIV     = 2;   // smallest legal divide value
    localparam int BCLK_NARROW = 8;   // master clocks per bit clock, 16-bit slots
    localparam int BCLK_WIDE   = 4;   // master clocks per bit clock, 32-bit slots
    localparam int SLOT_NARROW = 16;  // bit clocks per channel slot, narrow
    localparam int SLOT_WIDE   = 32;  // bit clocks per channel slot, wide

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             odd;
        logic             mclk;
        logic             wide;
    } acg_cfg_t;
endpackage

// File: rtl/acg_lin_div.sv
// Module: linear divider with duty reshaping. It divides by 2*N+O and
// gives a high phase of N+O cycles and a low phase of N cycles.
// Assumes N >= 2 (the parent clamps it) and settings held while en is high.
module acg_lin_div #(
    parameter int DIV_W = acg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] n_val,
    input  logic             odd,
    output logic             q,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] ratio_m1;
    logic [CW-1:0] hi_len;

    // Derive the period end and the length of the high phase.
    always_comb begin
        ratio_m1 = {n_val, 1'b0} + CW'(odd) - CW'(1);
        hi_len   = {1'b0, n_val} + CW'(odd);
    end

    // Phase counter that wraps once per divided period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == ratio_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Registered reshaped output: high during the first hi_len counts.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            q <= 1'b0;
        end else begin
            q <= (cnt < hi_len);
        end
    end

    // Edge ticks: asserted in the cycle before q rises or falls.
    assign rise_tick = en && (cnt == '0);
    assign fall_tick = en && (cnt == hi_len);
endmodule

// File: rtl/acg_post_div.sv
// Module: fixed post-divider that makes the bit clock from master-clock
// rising ticks, dividing by BCLK_NARROW or BCLK_WIDE according to the
// slot width. Assumes both ratios are even and the width held while en is high.
module acg_post_div #(
    parameter int NARROW = acg_pkg::BCLK_NARROW,
    parameter int WIDE   = acg_pkg::BCLK_WIDE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wide,
    input  logic tick,
    output logic bclk,
    output logic fall_tick
);
    localparam int MAXH = (NARROW > WIDE) ? NARROW / 2 : WIDE / 2;
    localparam int PW   = (MAXH > 1) ? $clog2(MAXH) : 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] half_m1;

    // Select the last count of one half period.
    always_comb begin
        half_m1 = wide ? PW'(WIDE / 2 - 1) : PW'(NARROW / 2 - 1);
    end

    // Count master-clock rising ticks and flip the bit clock at each half.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            pcnt <= (pcnt == half_m1) ? '0 : pcnt + PW'(1);
            if (pcnt == '0) begin
                bclk <= ~bclk;
            end
        end
    end

    // Falling edge of the bit clock occurs on this tick.
    assign fall_tick = tick && (pcnt == '0) && bclk;
endmodule

// File: rtl/acg_ws_gen.sv
// Module: word-select generator. It counts bit-clock falling ticks and
// toggles after one slot of SLOT_NARROW or SLOT_WIDE bits, so it changes
// on the bit-clock falling edge. Assumes the width held while en is high.
module acg_ws_gen #(
    parameter int NARROW = acg_pkg::SLOT_NARROW,
    parameter int WIDE   = acg_pkg::SLOT_WIDE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wide,
    input  logic fall_tick,
    output logic ws
);
    localparam int MAXS = (NARROW > WIDE) ? NARROW : WIDE;
    localparam int SW   = $clog2(MAXS);

    logic [SW-1:0] bcnt;
    logic [SW-1:0] last;

    // Select the last bit index of a slot.
    always_comb begin
        last = wide ? SW'(WIDE - 1) : SW'(NARROW - 1);
    end

    // Count slot bits and toggle word select at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bcnt <= '0;
            ws   <= 1'b0;
        end else if (fall_tick) begin
            if (bcnt == last) begin
                bcnt <= '0;
                ws   <= ~ws;
            end else begin
                bcnt <= bcnt + SW'(1);
            end
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
// Module: audio serial clock generator top. It captures the settings while
// idle, clamps the divide value, and drives the master clock, bit clock and
// word select. Assumes one source clock domain; outputs are registered
// signals, or muxes of them selected by held settings.
module audio_clkgen #(
    parameter int DIV_W = acg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_n,
    input  logic             odd_sel,
    input  logic             mclk_en,
    input  logic             frame32,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             ws_o
);
    import acg_pkg::*;

    acg_cfg_t         cfg_q;
    logic [DIV_W-1:0] n_eff;
    logic             lin_q, lin_rise, lin_fall;
    logic             post_bclk, post_fall;
    logic             bclk_fall;

    // Capture the settings on every edge at which the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{div: DIV_W'(MIN_DIV), odd: 1'b0, mclk: 1'b0, wide: 1'b0};
        end else if (!en) begin
            cfg_q <= '{div: div_n, odd: odd_sel, mclk: mclk_en, wide: frame32};
        end
    end

    // Replace divide values below the minimum with the minimum.
    always_comb begin
        n_eff = (cfg_q.div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cfg_q.div;
    end

    acg_lin_div #(.DIV_W(DIV_W)) u_lin (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .n_val     (n_eff),
        .odd       (cfg_q.odd),
        .q         (lin_q),
        .rise_tick (lin_rise),
        .fall_tick (lin_fall)
    );

    acg_post_div #(.NARROW(BCLK_NARROW), .WIDE(BCLK_WIDE)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en && cfg_q.mclk),
        .wide      (cfg_q.wide),
        .tick      (lin_rise),
        .bclk      (post_bclk),
        .fall_tick (post_fall)
    );

    // Pick the bit-clock source and its falling tick from the path setting.
    always_comb begin
        mclk_o    = cfg_q.mclk ? lin_q : 1'b0;
        bclk_o    = cfg_q.mclk ? post_bclk : lin_q;
        bclk_fall = cfg_q.mclk ? post_fall : lin_fall;
    end

    acg_ws_gen #(.NARROW(SLOT_NARROW), .WIDE(SLOT_WIDE)) u_ws (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wide      (cfg_q.wide),
        .fall_tick (bclk_fall),
        .ws        (ws_o)
    );
endmodule

// File: rtl/audio_clkgen_chk.sv
// Module: property checker for audio_clkgen, attached with bind. It
// observes the outputs and the captured settings only.
module audio_clkgen_chk #(
    parameter int DIV_W = acg_pkg::DIV_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             mclk_o,
    input logic             bclk_o,
    input logic             ws_o,
    input logic             cfg_mclk,
    input logic [DIV_W-1:0] cfg_div
);
    // R5: with the master-clock path off, the master clock stays low.
    assert_mclk_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mclk |-> !mclk_o);

    // R4: on the master-clock path the bit clock moves only with a master-clock rise.
    assert_bclk_on_mclk_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mclk && en && $past(en) && !$stable(bclk_o)) |-> $rose(mclk_o));

    // R6: during a run, word select changes only when the bit clock falls.
    assert_ws_on_bclk_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(ws_o)) |-> $fell(bclk_o));

    // R7: captured settings do not move while enabled.
    assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> ($stable(cfg_div) && $stable(cfg_mclk)));

    // R8: one edge after en is seen low, every output is low.
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!mclk_o && !bclk_o && !ws_o));
endmodule

bind audio_clkgen audio_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mclk_o   (mclk_o),
    .bclk_o   (bclk_o),
    .ws_o     (ws_o),
    .cfg_mclk (cfg_q.mclk),
    .cfg_div  (cfg_q.div)
);

// File: tb/audio_clkgen_test.sv
// Bench: directed scenarios for audio_clkgen. Expected waveforms are
// computed from closed forms indexed by the edge count since enable.
module audio_clkgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div_n = 8'd2;
    logic       odd_sel = 1'b0;
    logic       mclk_en = 1'b0;
    logic       frame32 = 1'b0;
    logic       mclk_o, bclk_o, ws_o;

    int tests = 0;
    int failed = 0;

    audio_clkgen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div_n   (div_n),
        .odd_sel (odd_sel),
        .mclk_en (mclk_en),
        .frame32 (frame32),
        .mclk_o  (mclk_o),
        .bclk_o  (bclk_o),
        .ws_o    (ws_o)
    );

    always #10 clk = ~clk;

    // Record one check; print a single FAIL line when it does not hold.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive settings with en low for two edges.
    task automatic setup(input int n, input bit o, input bit m, input bit w);
        @(negedge clk);
        en = 1'b0; div_n = 8'(n); odd_sel = o; mclk_en = m; frame32 = w;
        repeat (2) @(negedge clk);
    endtask

    // Enable, then compare each output with the closed forms for ncyc edges.
    task automatic run_mode(input int nin, input bit o, input bit m, input bit w,
                            input int ncyc, input bit poke, input string tag);
        int n, r, hi, h, slot, falls, pb;
        int em, eb, ew, exq;
        int bad_m, bad_b, bad_w, am, xm, ab, xb, aw, xw;
        n = (nin < 2) ? 2 : nin;
        r = 2 * n + o; hi = n + o;
        h = w ? 2 : 4; slot = w ? 32 : 16;
        falls = 0; pb = 0;
        bad_m = 0; bad_b = 0; bad_w = 0;
        am = 0; xm = 0; ab = 0; xb = 0; aw = 0; xw = 0;
        setup(nin, o, m, w);
        en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            exq = ((k % r) < hi) ? 1 : 0;
            em = m ? exq : 0;
            eb = m ? ((((k / r) / h) % 2 == 0) ? 1 : 0) : exq;
            if (pb == 1 && eb == 0) falls++;
            pb = eb;
            ew = (falls / slot) % 2;
            if (int'(mclk_o) != em && bad_m == 0) begin bad_m = 1; am = mclk_o; xm = em; end
            if (int'(bclk_o) != eb && bad_b == 0) begin bad_b = 1; ab = bclk_o; xb = eb; end
            if (int'(ws_o) != ew && bad_w == 0) begin bad_w = 1; aw = ws_o; xw = ew; end
            if (poke && k == 40) begin
                div_n = 8'd9; odd_sel = ~o; mclk_en = ~m; frame32 = ~w;
            end
        end
        check(bad_m == 0, {tag, " mclk_o"}, am, xm);
        check(bad_b == 0, {tag, " bclk_o"}, ab, xb);
        check(bad_w == 0, {tag, " ws_o"}, aw, xw);
    endtask

    // Reset state: all outputs low under reset, even with en high.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1;
        @(negedge clk);
        check(!mclk_o && !bclk_o && !ws_o, "R8 reset outputs low",
              {mclk_o, bclk_o, ws_o}, 0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Direct bit clock, even and odd ratios.
    task automatic t_direct();
        run_mode(3, 1'b0, 1'b0, 1'b0, 300, 1'b0, "R1/R5 even");
        run_mode(3, 1'b1, 1'b0, 1'b0, 400, 1'b0, "R2 odd");
        run_mode(5, 1'b1, 1'b0, 1'b1, 900, 1'b0, "R2/R6 odd wide");
    endtask

    // Master-clock path, both slot widths.
    task automatic t_mclk();
        run_mode(2, 1'b1, 1'b1, 1'b0, 1900, 1'b0, "R4/R6 narrow");
        run_mode(2, 1'b0, 1'b1, 1'b1, 1200, 1'b0, "R4/R6 wide");
    endtask

    // Divide values below two act as two.
    task automatic t_small_n();
        run_mode(0, 1'b1, 1'b0, 1'b0, 200, 1'b0, "R3 n0");
        run_mode(1, 1'b0, 1'b1, 1'b0, 300, 1'b0, "R3 n1");
    endtask

    // Setting changes while running are ignored.
    task automatic t_cfg_lock();
        run_mode(4, 1'b1, 1'b1, 1'b0, 1500, 1'b1, "R7 locked");
    endtask

    // Disable mid-run drives outputs low; re-enable restarts cleanly.
    task automatic t_disable();
        run_mode(2, 1'b1, 1'b1, 1'b0, 123, 1'b0, "R8 pre");
        en = 1'b0;
        @(negedge clk);
        check(!mclk_o && !bclk_o && !ws_o, "R8 disable outputs low",
              {mclk_o, bclk_o, ws_o}, 0);
        run_mode(2, 1'b1, 1'b1, 1'b0, 900, 1'b0, "R8 restart");
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_direct();
        t_mclk();
        t_small_n();
        t_cfg_lock();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule